// File: doc/BRIEF.md
# Status and Control Register Bank with Parity

This block sits behind the register port of a serial slave engine. It holds four read/write control registers and four read-only status registers. Each status register collects error events as sticky bits. When the master reads it, the byte is returned with a parity bit in the top bit, and the register is emptied once the master has read it. An active-low error output tells the master that at least one status bit is set.

The engine drives the chip-select level `cs_n`, already synchronised to `clk`, into the bank. Status contents and the error output change only on clock edges where `cs_n` is sampled high. During a frame they stay frozen, so a byte being shifted out cannot change under the engine. Events that arrive during a frame are held aside and merged when the frame ends. A clear requested by a read during a frame is also deferred until then.

The register port is made of plain strobes and never stalls. `rd_data` is a combinational function of `rd_addr`, so the engine can load its shift register in any cycle. A `wr_stb` takes effect on the next clock edge. There is no back-pressure in either direction, so no ready signal exists.

Top module: `stat_bank`

## Requirements
- R1: After reset all status and control registers are zero, `err_n` is 1, and every read address returns 0x00.
- R2: A read at address 4+k (k = 0..3) returns status register k. Bits 6:0 hold the latched events. Bit 7 is 1 when bits 6:0 contain an odd number of ones and 0 otherwise. Events for register k enter on `err_evt[7k+6:7k]`.
- R3: A write strobe to address k (k = 0..3) stores all 8 bits of `wr_data` on the next edge. The stored value appears on `ctrl_q[8k+7:8k]`, and a read of address k returns it unchanged, with no parity bit.
- R4: On an edge where `cs_n` is low, no status register changes. Events that arrive during that time are kept and merged on the first edge where `cs_n` is high.
- R5: A read strobe at a status address sets a pending clear for that register. The clear is applied on the first edge where `cs_n` is sampled high after the strobe.
- R6: A status bit, once set, stays set until a clear is applied. An event that arrives on the same edge as the clear survives the clear.
- R7: `err_n` is a register. It is 0 exactly when some status bit is set, and it holds its value on edges where `cs_n` is low.
- R8: A read of any address of 8 or above returns 0x00.
- R9: A write to a status address or to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Synchronised chip-select level; low while a frame is in progress |
| err_evt | input | 28 | Error event pulses, 7 bits per status register |
| rd_stb | input | 1 | Read strobe from the engine |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Byte at `rd_addr` (combinational) |
| wr_stb | input | 1 | Write strobe from the engine |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| ctrl_q | output | 32 | Control register contents, byte k = register k |
| err_n | output | 1 | Error flag, active low, registered |

## Verification
The assertions assume that `cs_n` is already synchronised to `clk`. They also assume that each strobe lasts one cycle and names a single address, so that a read hit selects at most one status register. The bench drives every input on the falling clock edge and holds each strobe for exactly one cycle. It raises `cs_n` only between complete read sequences. This keeps the stimulus inside those assumptions. It also places an event on the edge that applies a clear, so that the clear-versus-event case is exercised.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  parameter int STAT_W = 7;
  localparam int BYTE_W = STAT_W + 1;

  typedef logic [STAT_W-1:0] stat_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Result is 1 when the field holds an odd number of ones.
  function automatic logic odd_ones(stat_t v);
    return ^v;
  endfunction
endpackage

// File: rtl/sticky_stat_reg.sv
module sticky_stat_reg
  import stat_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n,
  input  stat_t evt,
  input  logic  rd_hit,
  output stat_t val,
  output stat_t val_d
);
  stat_t acc;   // events seen while the frame was active
  logic  pend;  // clear owed after a read

  always_comb begin
    if (cs_n) val_d = (val & ~{STAT_W{pend}}) | acc | evt;
    else      val_d = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val  <= '0;
      acc  <= '0;
      pend <= 1'b0;
    end else begin
      val <= val_d;
      if (cs_n) begin
        acc  <= '0;
        pend <= rd_hit;
      end else begin
        acc  <= acc | evt;
        pend <= pend | rd_hit;
      end
    end
  end

  AST_FROZEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(val)); // R4
  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !pend) |=> ((val & $past(val)) == $past(val))); // R6
  AST_EVENT_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ((val & $past(evt)) == $past(evt))); // R6
  AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && pend && acc == '0 && evt == '0) |=> (val == '0)); // R5
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import stat_bank_pkg::*;
#(
  parameter int NUM_CTRL = 4,
  parameter int ADDR_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  byte_t                      wr_data,
  output logic [NUM_CTRL*BYTE_W-1:0] q
);
  localparam logic [ADDR_W-1:0] CTRL_END = ADDR_W'(NUM_CTRL);

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[k*BYTE_W +: BYTE_W] <= '0;
      else if (wr_stb && wr_addr == ADDR_W'(k))
        q[k*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  AST_WRITE_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr >= CTRL_END) |=> $stable(q)); // R9
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_bank_pkg::*;
#(
  parameter int NUM_STAT = 4,
  parameter int NUM_CTRL = 4,
  parameter int ADDR_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic [NUM_STAT*STAT_W-1:0] err_evt,
  input  logic                       rd_stb,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [BYTE_W-1:0]          rd_data,
  input  logic                       wr_stb,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl_q,
  output logic                       err_n
);
  localparam int STAT_BITS = NUM_STAT * STAT_W;

  logic [STAT_BITS-1:0] stat_q;
  logic [STAT_BITS-1:0] stat_d;

  ctrl_regs #(.NUM_CTRL(NUM_CTRL), .ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .q       (ctrl_q)
  );

  for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
    logic hit;
    assign hit = rd_stb && (rd_addr == ADDR_W'(NUM_CTRL + k));
    sticky_stat_reg i_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .evt    (err_evt[k*STAT_W +: STAT_W]),
      .rd_hit (hit),
      .val    (stat_q[k*STAT_W +: STAT_W]),
      .val_d  (stat_d[k*STAT_W +: STAT_W])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_CTRL; k++)
      if (rd_addr == ADDR_W'(k))
        rd_data = ctrl_q[k*BYTE_W +: BYTE_W];
    for (int k = 0; k < NUM_STAT; k++)
      if (rd_addr == ADDR_W'(NUM_CTRL + k))
        rd_data = {odd_ones(stat_q[k*STAT_W +: STAT_W]),
                   stat_q[k*STAT_W +: STAT_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err_n <= 1'b1;
    else if (cs_n) err_n <= ~|stat_d;
  end

  AST_ERR_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    err_n == ~|stat_q); // R7
  AST_ERR_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(err_n)); // R7
endmodule

// File: tb/test_stat_bank.sv
module test_stat_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic [27:0] err_evt = '0;
  logic        rd_stb = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        wr_stb = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [31:0] ctrl_q;
  logic        err_n;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  stat_bank i_stat_bank (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .err_evt(err_evt),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .err_n(err_n)
  );

  typedef struct packed {
    logic [1:0] idx;
    logic [6:0] evt;
    logic [7:0] exp;
  } vec_t;

  // Expected bytes: bit 7 is 1 for an odd count of ones in bits 6:0 (R2).
  localparam vec_t VEC [8] = '{
    '{2'd0, 7'h01, 8'h81}, '{2'd1, 7'h03, 8'h03},
    '{2'd2, 7'h7F, 8'hFF}, '{2'd3, 7'h00, 8'h00},
    '{2'd0, 7'h55, 8'h55}, '{2'd3, 7'h2A, 8'hAA},
    '{2'd1, 7'h40, 8'hC0}, '{2'd2, 7'h36, 8'h36}
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic read_at(logic [4:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic pulse_evt(int idx, logic [6:0] v);
    err_evt = '0;
    err_evt[idx*7 +: 7] = v;
    @(negedge clk);
    err_evt = '0;
  endtask

  // Read strobe inside a frame, then end the frame.
  task automatic framed_read(logic [4:0] a);
    cs_n = 1'b0;
    @(negedge clk);
    rd_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic write_reg(logic [4:0] a, logic [7:0] d);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: got hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      read_at(5'(a), d);
      check("R1 read after reset", {24'h0, d}, 32'h0);
    end
    check("R1 ctrl_q after reset", ctrl_q, 32'h0);
    check("R1 err_n after reset", {31'h0, err_n}, 32'h1);

    // Table of events, parity and clear-on-read
    for (int i = 0; i < 8; i++) begin
      pulse_evt(int'(VEC[i].idx), VEC[i].evt);
      read_at(5'(4 + VEC[i].idx), d);
      check("R2 status byte with parity", {24'h0, d}, {24'h0, VEC[i].exp});
      check("R7 err_n follows status", {31'h0, err_n},
            {31'h0, (VEC[i].evt == 7'h0)});
      framed_read(5'(4 + VEC[i].idx));
      read_at(5'(4 + VEC[i].idx), d);
      check("R4 value held in frame after read", {24'h0, d}, {24'h0, VEC[i].exp});
      cs_n = 1'b1;
      @(negedge clk);
      read_at(5'(4 + VEC[i].idx), d);
      check("R5 cleared after frame", {24'h0, d}, 32'h0);
      check("R7 err_n released", {31'h0, err_n}, 32'h1);
    end

    // R3: control registers keep all 8 bits, no parity
    write_reg(5'd2, 8'hA5);
    read_at(5'd2, d);
    check("R3 control readback", {24'h0, d}, 32'hA5);
    check("R3 ctrl_q byte 2", ctrl_q, 32'h00A5_0000);
    write_reg(5'd0, 8'h01);
    read_at(5'd0, d);
    check("R3 control readback no parity", {24'h0, d}, 32'h01);

    // R9: writes to status and unmapped addresses ignored
    write_reg(5'd5, 8'h7F);
    read_at(5'd5, d);
    check("R9 status write ignored", {24'h0, d}, 32'h0);
    check("R9 ctrl_q unchanged", ctrl_q, 32'h00A5_0001);
    check("R9 err_n unchanged", {31'h0, err_n}, 32'h1);
    write_reg(5'h1F, 8'hFF);
    check("R9 unmapped write ignored", ctrl_q, 32'h00A5_0001);

    // R8: unmapped reads
    read_at(5'h08, d);
    check("R8 read 0x08", {24'h0, d}, 32'h0);
    read_at(5'h1F, d);
    check("R8 read 0x1F", {24'h0, d}, 32'h0);

    // R4: event during a frame is frozen, then merged
    cs_n = 1'b0;
    @(negedge clk);
    pulse_evt(1, 7'h01);
    read_at(5'd5, d);
    check("R4 frozen during frame", {24'h0, d}, 32'h0);
    check("R4 err_n frozen during frame", {31'h0, err_n}, 32'h1);
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    read_at(5'd5, d);
    check("R4 merged after frame", {24'h0, d}, 32'h81);
    check("R7 err_n after merge", {31'h0, err_n}, 32'h0);
    framed_read(5'd5);
    cs_n = 1'b1;
    @(negedge clk);

    // R6: sticky bit, and event on the clearing edge survives
    pulse_evt(2, 7'h01);
    pulse_evt(2, 7'h04);
    read_at(5'd6, d);
    check("R6 sticky accumulation", {24'h0, d}, 32'h05);
    framed_read(5'd6);
    cs_n = 1'b1;
    err_evt[14 +: 7] = 7'h02;
    @(negedge clk);
    err_evt = '0;
    read_at(5'd6, d);
    check("R6 event beats clear", {24'h0, d}, 32'h82);
    check("R7 err_n with surviving event", {31'h0, err_n}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule